// File: doc/BRIEF.md
# Segmented Associative Data Cache Controller

This block sits between a processor's load/store port and the external memory path. It keeps lines of four 32-bit words in a small number of segments. Each segment is a fully associative set of ways. Address bits [5:4] pick the segment. All address bits above bit 5 form the tag, and the tag is compared against every way of that segment at once. Reads that hit complete in one cycle. A cacheable read that misses allocates a way and refills the whole line with one four-beat burst. Stores never allocate.

Each access carries two attribute bits. The cacheable bit allows a lookup. For a store hit, the bufferable bit chooses the policy: when set, the store is written back later and the line is marked dirty; when clear, the store is written through to the write buffer and the line stays clean. Every store that misses is forwarded to the write buffer.

When a refill chooses a victim that is valid and dirty, the controller first sends that line to the write buffer as four word writes, lowest address first. Only then does it issue the refill. A global enable forces every access to be treated as non-cacheable while the stored lines are left untouched. Reset invalidates every line.

Top module: `seg_dcache`

## Requirements
- R1: A cacheable read that hits returns the stored word with `ack` high in the cycle after `req`. `busy` stays low, and no refill or write-buffer traffic occurs.
- R2: A cacheable read that misses raises `fill_req` for exactly one cycle, with `fill_burst`=1 and `fill_addr` aligned to the 16-byte line. It takes four beats, returns the requested word, and after it the line hits.
- R3: A store that misses makes exactly one write-buffer transfer carrying the store address and data. It allocates no line, so a later read of that address misses.
- R4: A store hit with bufferable=1 updates the line, makes no write-buffer transfer and marks the line dirty.
- R5: A store hit with bufferable=0 updates the line and makes exactly one write-buffer transfer. The line stays clean, so evicting it later produces no write-back.
- R6: Evicting a valid dirty line sends its four words to the write buffer at line base +0, +4, +8, +12 in that order, all before `fill_req`. `wb_valid`, `wb_addr` and `wb_data` hold steady while `wb_ready` is low.
- R7: Bits [5:4] select one of four segments, and bits [31:6] are the tag. Each segment holds 64 distinct lines at the same time, and no two valid ways of a segment ever match one lookup.
- R8: Each segment chooses its victim with its own round-robin counter, which advances on each allocation in that segment only. After a segment is full, the 65th allocation replaces the oldest line, and the next one replaces the second oldest.
- R9: With `cache_en`=0, or with cacheable=0, a read is a single-word external read (`fill_burst`=0, `fill_addr` = the access address) and a store goes to the write buffer.
- R10: Lines stay in place while the cache is disabled, and a store made while disabled does not update them. After re-enabling, the old word is returned as a hit.
- R11: Reset invalidates every line, so an address cached before reset misses afterwards. Out of reset, `busy`, `ack`, `wb_valid` and `fill_req` are low.
- R12: `busy` is high from the cycle after a request that needs external traffic until the cycle of its `ack`. `ack` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Global cache enable |
| req | input | 1 | One-cycle access request, accepted while `busy` is low |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Physical byte address, word aligned |
| req_wdata | input | 32 | Store data |
| req_cacheable | input | 1 | Cacheable attribute of the access |
| req_bufferable | input | 1 | Bufferable attribute (1 = write-back on a store hit) |
| busy | output | 1 | Controller is working on an external transfer |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Load data, valid while `ack` is high |
| wb_valid | output | 1 | Write-buffer transfer offered |
| wb_ready | input | 1 | Write buffer accepts the transfer |
| wb_addr | output | 32 | Write-buffer address |
| wb_data | output | 32 | Write-buffer data |
| fill_req | output | 1 | One-cycle external read request |
| fill_burst | output | 1 | 1 = four-word line refill, 0 = single word |
| fill_addr | output | 32 | External read address |
| fill_valid | input | 1 | Read beat valid |
| fill_data | input | 32 | Read beat data |

## Verification
The bench fills one segment with all 64 ways and then forces a dirty eviction. A design with a wrong segment slice or a shared victim counter would lose lines early or pick the wrong way. A design that put the refill before the write-back, or wrote the words in the wrong order, would show up in the logged order of write-buffer transfers. A further check evicts a line that was written through. A design that set the dirty bit on that store would produce four extra transfers. Other checks store while the cache is disabled and then re-enable it, and flush with reset. A design that updated the cache while disabled would return the new word instead of the old one, and one that lost lines on disable, or kept them through reset, would report the wrong number of refills.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBUF,
    ST_EVICT,
    ST_FREQ,
    ST_FILL
  } sdc_state_e;
endpackage

// File: rtl/sdc_tag_store.sv
module sdc_tag_store #(
  parameter int SEGS  = 4,
  parameter int WAYS  = 64,
  parameter int TAG_W = 26
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [$clog2(SEGS)-1:0]               lk_seg,
  input  logic [TAG_W-1:0]                      lk_tag,
  output logic                                  lk_hit,
  output logic [$clog2(WAYS)-1:0]               lk_way,
  input  logic [$clog2(SEGS)+$clog2(WAYS)-1:0]  vr_line,
  output logic                                  vr_valid,
  output logic                                  vr_dirty,
  output logic [TAG_W-1:0]                      vr_tag,
  input  logic                                  al_en,
  input  logic [$clog2(SEGS)+$clog2(WAYS)-1:0]  al_line,
  input  logic [TAG_W-1:0]                      al_tag,
  input  logic                                  dset_en,
  input  logic [$clog2(SEGS)+$clog2(WAYS)-1:0]  dset_line
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LINES = SEGS * WAYS;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] val_q, val_d, dty_q, dty_d;
  logic [WAYS-1:0]  match;

  // parallel compare of every way in the selected segment
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      match[w] = val_q[{lk_seg, WAY_W'(w)}] && (tag_q[{lk_seg, WAY_W'(w)}] == lk_tag);
    end
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) lk_way = WAY_W'(w);
    end
  end

  assign lk_hit   = |match;
  assign vr_valid = val_q[vr_line];
  assign vr_dirty = dty_q[vr_line];
  assign vr_tag   = tag_q[vr_line];

  always_comb begin
    val_d = val_q;
    dty_d = dty_q;
    if (al_en) begin
      val_d[al_line] = 1'b1;
      dty_d[al_line] = 1'b0;
    end
    if (dset_en) dty_d[dset_line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
    end else begin
      val_q <= val_d;
      dty_q <= dty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (al_en) tag_q[al_line] <= al_tag;
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R7
endmodule

// File: rtl/sdc_victim.sv
module sdc_victim #(
  parameter int SEGS = 4,
  parameter int WAYS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SEGS)-1:0]  sel_seg,
  input  logic                     adv_en,
  input  logic [$clog2(SEGS)-1:0]  adv_seg,
  output logic [$clog2(WAYS)-1:0]  vic_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int SEG_W = $clog2(SEGS);

  logic [WAY_W-1:0] rr_all [SEGS];

  for (genvar g = 0; g < SEGS; g++) begin : g_rr
    logic             step;
    logic [WAY_W-1:0] rr_q, rr_d;

    assign step = adv_en && (adv_seg == SEG_W'(g));
    assign rr_d = rr_q + WAY_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rr_q <= '0;
      else if (step) rr_q <= rr_d;
    end

    assign rr_all[g] = rr_q;
  end

  assign vic_way = rr_all[sel_seg];
endmodule

// File: rtl/sdc_data_store.sv
module sdc_data_store #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output logic [DATA_W-1:0]         rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/seg_dcache.sv
module seg_dcache
  import sdc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SEGS       = 4,
  parameter int WAYS       = 64,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_cacheable,
  input  logic              req_bufferable,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              fill_req,
  output logic              fill_burst,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WB_W    = $clog2(LINE_WORDS);
  localparam int SEG_W   = $clog2(SEGS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LINE_W  = SEG_W + WAY_W;
  localparam int SEG_LSB = BYTE_W + WB_W;
  localparam int TAG_LSB = SEG_LSB + SEG_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int DEPTH   = SEGS * WAYS * LINE_WORDS;
  localparam int DIDX_W  = LINE_W + WB_W;
  localparam logic [WB_W-1:0] LAST_BEAT = WB_W'(LINE_WORDS - 1);

  sdc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] rq_addr_q, rq_addr_d;
  logic [DATA_W-1:0] rq_wdata_q, rq_wdata_d;
  logic              rq_burst_q, rq_burst_d;
  logic [LINE_W-1:0] vic_line_q, vic_line_d;
  logic [TAG_W-1:0]  vic_tag_q, vic_tag_d;
  logic [WB_W-1:0]   beat_q, beat_d;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic              cached;
  logic [SEG_W-1:0]  lk_seg;
  logic [TAG_W-1:0]  lk_tag;
  logic [WB_W-1:0]   lk_word;
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic [WAY_W-1:0]  vic_way;
  logic              vr_valid, vr_dirty;
  logic [TAG_W-1:0]  vr_tag;
  logic              al_en, adv_en, dset_en;
  logic              dw_en;
  logic [DIDX_W-1:0] dw_idx, dr_idx;
  logic [DATA_W-1:0] dw_data, dr_data;

  assign cached  = cache_en && req_cacheable;
  assign lk_seg  = req_addr[SEG_LSB +: SEG_W];
  assign lk_tag  = req_addr[ADDR_W-1:TAG_LSB];
  assign lk_word = req_addr[BYTE_W +: WB_W];

  sdc_tag_store #(.SEGS(SEGS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_seg   (lk_seg),
    .lk_tag   (lk_tag),
    .lk_hit   (lk_hit),
    .lk_way   (lk_way),
    .vr_line  ({lk_seg, vic_way}),
    .vr_valid (vr_valid),
    .vr_dirty (vr_dirty),
    .vr_tag   (vr_tag),
    .al_en    (al_en),
    .al_line  (vic_line_q),
    .al_tag   (rq_addr_q[ADDR_W-1:TAG_LSB]),
    .dset_en  (dset_en),
    .dset_line({lk_seg, lk_way})
  );

  sdc_victim #(.SEGS(SEGS), .WAYS(WAYS)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_seg(lk_seg),
    .adv_en (adv_en),
    .adv_seg(vic_line_q[LINE_W-1 -: SEG_W]),
    .vic_way(vic_way)
  );

  sdc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .wr_en  (dw_en),
    .wr_idx (dw_idx),
    .wr_data(dw_data),
    .rd_idx (dr_idx),
    .rd_data(dr_data)
  );

  always_comb begin
    state_d    = state_q;
    rq_addr_d  = rq_addr_q;
    rq_wdata_d = rq_wdata_q;
    rq_burst_d = rq_burst_q;
    vic_line_d = vic_line_q;
    vic_tag_d  = vic_tag_q;
    beat_d     = beat_q;
    ack_d      = 1'b0;
    rdata_d    = rdata_q;
    al_en      = 1'b0;
    adv_en     = 1'b0;
    dset_en    = 1'b0;
    dw_en      = 1'b0;
    dw_idx     = {lk_seg, lk_way, lk_word};
    dw_data    = req_wdata;
    dr_idx     = {lk_seg, lk_way, lk_word};
    wb_valid   = 1'b0;
    wb_addr    = rq_addr_q;
    wb_data    = rq_wdata_q;
    fill_req   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          rq_addr_d  = req_addr;
          rq_wdata_d = req_wdata;
          if (!req_we) begin
            if (cached && lk_hit) begin
              ack_d   = 1'b1;
              rdata_d = dr_data;
            end else if (cached) begin
              rq_burst_d = 1'b1;
              vic_line_d = {lk_seg, vic_way};
              vic_tag_d  = vr_tag;
              beat_d     = '0;
              state_d    = (vr_valid && vr_dirty) ? ST_EVICT : ST_FREQ;
            end else begin
              rq_burst_d = 1'b0;
              state_d    = ST_FREQ;
            end
          end else if (cached && lk_hit) begin
            dw_en = 1'b1;
            if (req_bufferable) begin
              dset_en = 1'b1;
              ack_d   = 1'b1;
            end else begin
              state_d = ST_WBUF;
            end
          end else begin
            state_d = ST_WBUF;
          end
        end
      end
      ST_WBUF: begin
        wb_valid = 1'b1;
        if (wb_ready) begin
          ack_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_EVICT: begin
        dr_idx   = {vic_line_q, beat_q};
        wb_valid = 1'b1;
        wb_addr  = {vic_tag_q, vic_line_q[LINE_W-1 -: SEG_W], beat_q, BYTE_W'(0)};
        wb_data  = dr_data;
        if (wb_ready) begin
          beat_d = beat_q + WB_W'(1);
          if (beat_q == LAST_BEAT) state_d = ST_FREQ;
        end
      end
      ST_FREQ: begin
        fill_req = 1'b1;
        beat_d   = '0;
        state_d  = ST_FILL;
      end
      ST_FILL: begin
        if (fill_valid) begin
          if (rq_burst_q) begin
            dw_en   = 1'b1;
            dw_idx  = {vic_line_q, beat_q};
            dw_data = fill_data;
            if (beat_q == rq_addr_q[BYTE_W +: WB_W]) rdata_d = fill_data;
            beat_d = beat_q + WB_W'(1);
            if (beat_q == LAST_BEAT) begin
              al_en   = 1'b1;
              adv_en  = 1'b1;
              ack_d   = 1'b1;
              state_d = ST_IDLE;
            end
          end else begin
            rdata_d = fill_data;
            ack_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
      rq_burst_q <= 1'b0;
      vic_line_q <= '0;
      vic_tag_q  <= '0;
      beat_q     <= '0;
      ack_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      state_q    <= state_d;
      rq_addr_q  <= rq_addr_d;
      rq_wdata_q <= rq_wdata_d;
      rq_burst_q <= rq_burst_d;
      vic_line_q <= vic_line_d;
      vic_tag_q  <= vic_tag_d;
      beat_q     <= beat_d;
      ack_q      <= ack_d;
      rdata_q    <= rdata_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign ack        = ack_q;
  assign rdata      = rdata_q;
  assign fill_burst = rq_burst_q;
  assign fill_addr  = rq_burst_q ? {rq_addr_q[ADDR_W-1:SEG_LSB], SEG_LSB'(0)} : rq_addr_q;

  AST_HIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && !req_we && cached && lk_hit) |=> (ack && !busy)); // R1
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !fill_req); // R2
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R6
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy); // R12
endmodule

// File: tb/seg_dcache_bench.sv
`timescale 1ns/1ps
module seg_dcache_bench;
  typedef struct packed {
    logic        we;
    logic        en;
    logic        c;
    logic        b;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  fills;
    logic [3:0]  wbs;
    logic [3:0]  rq;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h1000, 32'h0, 32'hC3A51000, 4'd1, 4'd0, 4'd2},       // R2 miss
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h1008, 32'h0, 32'hC3A51008, 4'd0, 4'd0, 4'd1},       // R1 hit
    '{1'b1, 1'b1, 1'b1, 1'b1, 32'h1004, 32'h11110004, 32'h0, 4'd0, 4'd0, 4'd4},       // R4 WB hit
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h1004, 32'h0, 32'h11110004, 4'd0, 4'd0, 4'd4},       // R4
    '{1'b1, 1'b1, 1'b1, 1'b0, 32'h2010, 32'h22220010, 32'h0, 4'd0, 4'd1, 4'd3},       // R3 store miss
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h2010, 32'h0, 32'hC3A52010, 4'd1, 4'd0, 4'd3},       // R3 no alloc
    '{1'b1, 1'b1, 1'b1, 1'b0, 32'h2014, 32'h33330014, 32'h0, 4'd0, 4'd1, 4'd5},       // R5 WT hit
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h2014, 32'h0, 32'h33330014, 4'd0, 4'd0, 4'd5},       // R5
    '{1'b0, 1'b1, 1'b0, 1'b0, 32'h3000, 32'h0, 32'hC3A53000, 4'd1, 4'd0, 4'd9},       // R9 uncached
    '{1'b1, 1'b0, 1'b1, 1'b1, 32'h1000, 32'h44441000, 32'h0, 4'd0, 4'd1, 4'd10},      // R10 disabled store
    '{1'b0, 1'b0, 1'b1, 1'b1, 32'h1000, 32'h0, 32'hC3A51000, 4'd1, 4'd0, 4'd9},       // R9 disabled read
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h1000, 32'h0, 32'hC3A51000, 4'd0, 4'd0, 4'd10},      // R10 stale hit
    '{1'b0, 1'b1, 1'b1, 1'b1, 32'h1004, 32'h0, 32'h11110004, 4'd0, 4'd0, 4'd10}       // R10 kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_cacheable = 1'b1;
  logic        req_bufferable = 1'b1;
  logic        busy, ack;
  logic [31:0] rdata;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [31:0] wb_addr, wb_data;
  logic        fill_req, fill_burst;
  logic [31:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;

  int errors = 0;
  int checks = 0;
  int fill_cnt = 0;
  int wb_cnt = 0;
  logic [31:0] last_fill_addr = '0;
  logic        last_fill_burst = 1'b0;
  logic [31:0] wb_a [64];
  logic [31:0] wb_d [64];
  int          wb_f [64];

  always #2.5 clk = ~clk;

  seg_dcache u_seg_dcache (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cacheable(req_cacheable),
    .req_bufferable(req_bufferable), .busy(busy), .ack(ack), .rdata(rdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .fill_req(fill_req), .fill_burst(fill_burst), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    return a ^ 32'hC3A5_0000;
  endfunction

  // external memory: latches a one-cycle request, then streams beats
  logic        srv = 1'b0;
  logic [31:0] base = '0;
  int          nb = 0;
  int          k = 0;
  always @(posedge clk) begin
    fill_valid <= 1'b0;
    if (srv) begin
      fill_valid <= 1'b1;
      fill_data  <= mw(base + 32'(k * 4));
      if (k == nb - 1) srv <= 1'b0;
      k <= k + 1;
    end else if (fill_req) begin
      srv  <= 1'b1;
      base <= fill_addr;
      nb   <= fill_burst ? 4 : 1;
      k    <= 0;
    end
  end

  always @(posedge clk) begin
    if (fill_req) begin
      fill_cnt++;
      last_fill_addr  = fill_addr;
      last_fill_burst = fill_burst;
    end
    if (wb_valid && wb_ready) begin
      wb_a[wb_cnt % 64] = wb_addr;
      wb_d[wb_cnt % 64] = wb_data;
      wb_f[wb_cnt % 64] = fill_cnt;
      wb_cnt++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic en, input logic c, input logic b,
                        input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int nf, output int nw);
    int f0, w0, t;
    f0 = fill_cnt;
    w0 = wb_cnt;
    t  = 0;
    @(negedge clk);
    cache_en = en; req_we = we; req_cacheable = c; req_bufferable = b;
    req_addr = a; req_wdata = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!ack && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(ack == 1'b1, "R12", "ack seen", 32'(ack), 32'd1);
    rd = rdata;
    nf = fill_cnt - f0;
    nw = wb_cnt - w0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int nf, nw, w0, f0;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0 && ack == 1'b0 && wb_valid == 1'b0 && fill_req == 1'b0,
        "R11", "reset outputs", {busy, ack, wb_valid, fill_req}, 32'd0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i].we, VEC[i].en, VEC[i].c, VEC[i].b, VEC[i].addr, VEC[i].wdata, rd, nf, nw);
      chk(nf == int'(VEC[i].fills), $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d fills", i),
          32'(nf), 32'(VEC[i].fills));
      chk(nw == int'(VEC[i].wbs), $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d wb writes", i),
          32'(nw), 32'(VEC[i].wbs));
      if (!VEC[i].we)
        chk(rd == VEC[i].exp, $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d rdata", i),
            rd, VEC[i].exp);
      if (VEC[i].we && nw == 1)
        chk(wb_a[(wb_cnt - 1) % 64] == VEC[i].addr && wb_d[(wb_cnt - 1) % 64] == VEC[i].wdata,
            "R3", $sformatf("vec %0d wb addr", i), wb_a[(wb_cnt - 1) % 64], VEC[i].addr);
      if (!VEC[i].we && nf == 1) begin
        if (VEC[i].en && VEC[i].c)
          chk(last_fill_burst && last_fill_addr == (VEC[i].addr & 32'hFFFF_FFF0), "R2",
              $sformatf("vec %0d burst fill addr", i), last_fill_addr, VEC[i].addr & 32'hFFFF_FFF0);
        else
          chk(!last_fill_burst && last_fill_addr == VEC[i].addr, "R9",
              $sformatf("vec %0d single fill addr", i), last_fill_addr, VEC[i].addr);
      end
    end

    // R1: hit completes in the next cycle with busy low
    @(negedge clk);
    cache_en = 1'b1; req_we = 1'b0; req_cacheable = 1'b1; req_bufferable = 1'b1;
    req_addr = 32'h1008; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(ack && !busy && rdata == 32'hC3A51008, "R1", "single-cycle hit", rdata, 32'hC3A51008);

    // R12: busy rises on a miss; R7 fill segment 0 with 63 more lines
    for (int i = 0; i < 63; i++) begin
      logic [31:0] a;
      a = 32'h10000 + 32'(i * 64) + 32'((i % 4) * 4);
      if (i == 0) begin
        @(negedge clk);
        req_we = 1'b0; req_addr = a; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1 && ack == 1'b0, "R12", "busy after miss", 32'(busy), 32'd1);
        while (!ack) @(negedge clk);
        chk(rdata == mw(a), "R2", "first fill word", rdata, mw(a));
      end else begin
        access(1'b0, 1'b1, 1'b1, 1'b1, a, 32'h0, rd, nf, nw);
        chk(nf == 1 && nw == 0 && rd == mw(a), "R7", $sformatf("fill way %0d", i + 1), rd, mw(a));
      end
    end
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'h1004, 32'h0, rd, nf, nw);
    chk(nf == 0 && rd == 32'h11110004, "R7", "64 lines resident", rd, 32'h11110004);

    // R6: 65th allocation evicts the dirty oldest line first
    w0 = wb_cnt;
    f0 = fill_cnt;
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'h20000, 32'h0, rd, nf, nw);
    chk(nw == 4 && nf == 1, "R6", "eviction writes", 32'(nw), 32'd4);
    for (int j = 0; j < 4; j++) begin
      logic [31:0] ed;
      ed = (j == 1) ? 32'h11110004 : mw(32'h1000 + 32'(j * 4));
      chk(wb_a[(w0 + j) % 64] == 32'h1000 + 32'(j * 4), "R6", $sformatf("evict addr %0d", j),
          wb_a[(w0 + j) % 64], 32'h1000 + 32'(j * 4));
      chk(wb_d[(w0 + j) % 64] == ed, "R6", $sformatf("evict data %0d", j), wb_d[(w0 + j) % 64], ed);
      chk(wb_f[(w0 + j) % 64] == f0, "R6", "evict before refill", 32'(wb_f[(w0 + j) % 64]), 32'(f0));
    end
    chk(rd == mw(32'h20000), "R8", "victim refill data", rd, mw(32'h20000));

    // R5 and R8: write-through line evicted next without a write-back
    access(1'b1, 1'b1, 1'b1, 1'b0, 32'h10000, 32'h55550000, rd, nf, nw);
    chk(nw == 1 && nf == 0, "R5", "WT hit writes through", 32'(nw), 32'd1);
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'h1000, 32'h0, rd, nf, nw);
    chk(nf == 1 && nw == 0, "R5", "clean victim no write-back", 32'(nw), 32'd0);
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'h10000, 32'h0, rd, nf, nw);
    chk(nf == 1 && rd == mw(32'h10000), "R8", "second oldest replaced", 32'(nf), 32'd1);
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'h2014, 32'h0, rd, nf, nw);
    chk(nf == 0 && rd == 32'h33330014, "R8", "other segment untouched", rd, 32'h33330014);

    // R6 / R12: write buffer stall keeps busy and holds the transfer
    @(negedge clk);
    wb_ready = 1'b0;
    w0 = wb_cnt;
    req_we = 1'b1; req_cacheable = 1'b0; req_addr = 32'h5000; req_wdata = 32'h66665000; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy && wb_valid && !ack && wb_addr == 32'h5000, "R12", "stalled store", wb_addr, 32'h5000);
    wb_ready = 1'b1;
    while (!ack) @(negedge clk);
    chk(wb_cnt - w0 == 1 && wb_d[w0 % 64] == 32'h66665000, "R9", "uncached store to wb",
        wb_d[w0 % 64], 32'h66665000);

    // R11: reset flushes
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !ack && !wb_valid && !fill_req, "R11", "outputs in reset",
        {busy, ack, wb_valid, fill_req}, 32'd0);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'h2014, 32'h0, rd, nf, nw);
    chk(nf == 1 && rd == mw(32'h2014), "R11", "miss after reset", 32'(nf), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule